// File: doc/BRIEF.md
# In-Order Retirement Buffer with Precise Traps

This block tracks instructions that an out-of-order core has issued but not yet committed. Instructions are entered in program order, each carrying its instruction address, and receive a slot tag that the execution side later uses to report completion. Completions may arrive in any order and may carry a fault flag. The buffer commits instructions only from its oldest slot. Each commit is reported on the retire port, and a committed store is released to memory in that same cycle, never earlier.

Faults and external interrupt requests are acted on only at the commit point. A fault is recorded against its slot when reported, but it is delivered only once that slot is the oldest. An interrupt request is latched and taken at the oldest slot, between two commits. In both cases the block reports the address at which execution must resume and discards every uncommitted instruction. A two-state controller runs the buffer. In RS_RUN it commits or decides on a trap. When it takes a fault or an interrupt, it makes the transition RUN-to-FLUSH. In RS_FLUSH it presents the trap for one cycle, clears every slot and blocks new entries. It then makes the unconditional transition FLUSH-to-RUN.

Top module: `rob_core`

## Requirements
- R1: An entry is accepted on a cycle with alloc_valid and alloc_ready both high. alloc_tag gives the slot it takes. The tag advances by one per accepted entry and wraps from DEPTH-1 to 0.
- R2: alloc_ready is low whenever all DEPTH slots are occupied.
- R3: retire_valid is high only when the oldest occupied slot has completed without a fault. retire_pc is that slot's address. Commits follow the order in which the entries were accepted.
- R4: Completions reported with cmpl_tag may arrive in any order. A completed younger entry waits until every older entry has committed.
- R5: A fault reported on a slot causes no action until that slot is the oldest. That slot is then never committed. A trap follows with trap_cause 0, and trap_pc is the faulting slot's address.
- R6: store_release is high exactly in the cycles in which retire_valid is high for an entry accepted with alloc_is_store set.
- R7: An irq_req pulse is latched until it is taken. It is taken only while at least one slot is occupied, in a cycle with no commit. The trap that follows has trap_cause 1, and trap_pc is the address of the oldest uncommitted entry.
- R8: If the oldest slot is complete with a fault while an interrupt is pending, the fault trap is taken. The interrupt stays pending for a later trap.
- R9: A trap is decided in one cycle, and trap_valid is high for exactly one cycle after that. In that trap cycle, alloc_ready and retire_valid are low. Afterwards the buffer is empty, and the next tag equals the oldest slot index at the time of the trap.
- R10: After reset the buffer is empty, alloc_ready is high, alloc_tag is 0 and retire_valid, store_release and trap_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | New instruction offered in program order |
| alloc_pc | input | PC_W | Address of the offered instruction |
| alloc_is_store | input | 1 | Offered instruction writes memory |
| alloc_ready | output | 1 | A slot is free and no flush is under way |
| alloc_tag | output | IDX_W | Slot the offered instruction takes |
| cmpl_valid | input | 1 | Completion report |
| cmpl_tag | input | IDX_W | Slot being completed |
| cmpl_fault | input | 1 | Completion carries a fault |
| irq_req | input | 1 | External interrupt request, latched |
| retire_valid | output | 1 | Oldest entry commits this cycle |
| retire_pc | output | PC_W | Address of the committing entry |
| store_release | output | 1 | Committing entry is a store, release it to memory |
| trap_valid | output | 1 | Trap cycle: flush, and redirect after the handler |
| trap_cause | output | 1 | 0 fault, 1 interrupt |
| trap_pc | output | PC_W | Address at which execution resumes |

## Verification
The properties assume that completions name only slots that are occupied and not yet completed, each slot being reported at most once. They also assume that entries are offered only while alloc_ready is high or are simply held back otherwise. The stimulus keeps to this by picking every completion tag from the bench's own list of outstanding slots. It also counts an offer as accepted only when alloc_ready was high in that cycle. Random traffic is mixed with directed cases. One fills the buffer and completes its slots in reverse order. Another makes a fault at the oldest slot coincide with a fresh interrupt request, and then lets the interrupt wait on an empty buffer.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [0:0] {
        RS_RUN   = 1'b0,
        RS_FLUSH = 1'b1
    } rob_state_e;

    localparam logic CAUSE_FAULT = 1'b0;
    localparam logic CAUSE_IRQ   = 1'b1;

endpackage

// File: rtl/rob_entry_array.sv
module rob_entry_array #(
    parameter int DEPTH = 16,
    parameter int PC_W  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PC_W-1:0]  wr_pc,
    input  logic             wr_store,
    input  logic             cmp_en,
    input  logic [IDX_W-1:0] cmp_idx,
    input  logic             cmp_fault,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             flush_all,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_done,
    output logic             rd_fault,
    output logic             rd_store,
    output logic [PC_W-1:0]  rd_pc
);

    logic [DEPTH-1:0] valid_vec;
    logic [DEPTH-1:0] done_vec;
    logic [DEPTH-1:0] fault_vec;
    logic [DEPTH-1:0] store_vec;
    logic [PC_W-1:0]  pc_arr [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic            v_q;
        logic            d_q;
        logic            f_q;
        logic            s_q;
        logic [PC_W-1:0] pc_q;
        logic            hit_wr;
        logic            hit_cmp;
        logic            hit_clr;

        assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(i));
        assign hit_cmp = cmp_en && (cmp_idx == IDX_W'(i)) && v_q;
        assign hit_clr = clr_en && (clr_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q  <= 1'b0;
                d_q  <= 1'b0;
                f_q  <= 1'b0;
                s_q  <= 1'b0;
                pc_q <= '0;
            end else if (flush_all) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                f_q <= 1'b0;
            end else if (hit_wr) begin
                v_q  <= 1'b1;
                d_q  <= 1'b0;
                f_q  <= 1'b0;
                s_q  <= wr_store;
                pc_q <= wr_pc;
            end else begin
                if (hit_cmp) begin
                    d_q <= 1'b1;
                    f_q <= cmp_fault;
                end
                if (hit_clr) begin
                    v_q <= 1'b0;
                    d_q <= 1'b0;
                end
            end
        end

        assign valid_vec[i] = v_q;
        assign done_vec[i]  = d_q;
        assign fault_vec[i] = f_q;
        assign store_vec[i] = s_q;
        assign pc_arr[i]    = pc_q;
    end

    assign rd_valid = valid_vec[rd_idx];
    assign rd_done  = done_vec[rd_idx];
    assign rd_fault = fault_vec[rd_idx];
    assign rd_store = store_vec[rd_idx];
    assign rd_pc    = pc_arr[rd_idx];

endmodule

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             full,
    output logic [CNT_W-1:0] occ
);

    logic [IDX_W-1:0] head_q;
    logic [IDX_W-1:0] tail_q;
    logic             full_q;
    logic [IDX_W-1:0] head_inc;
    logic [IDX_W-1:0] tail_inc;

    assign head_inc = (head_q == IDX_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
    assign tail_inc = (tail_q == IDX_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            full_q <= 1'b0;
        end else if (flush) begin
            tail_q <= head_q;
            full_q <= 1'b0;
        end else begin
            if (push) begin
                tail_q <= tail_inc;
            end
            if (pop) begin
                head_q <= head_inc;
            end
            if (push && !pop && (tail_inc == head_q)) begin
                full_q <= 1'b1;
            end else if (pop && !push) begin
                full_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (full_q) begin
            occ = CNT_W'(DEPTH);
        end else if (tail_q >= head_q) begin
            occ = CNT_W'(tail_q - head_q);
        end else begin
            occ = CNT_W'(DEPTH) - CNT_W'(head_q) + CNT_W'(tail_q);
        end
    end

    assign head = head_q;
    assign tail = tail_q;
    assign full = full_q;

endmodule

// File: rtl/rob_retire_fsm.sv
module rob_retire_fsm
    import rob_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hd_valid,
    input  logic            hd_done,
    input  logic            hd_fault,
    input  logic [PC_W-1:0] hd_pc,
    input  logic            irq_pend,
    output logic            retire_go,
    output logic            take_irq,
    output logic            flushing,
    output logic            trap_cause,
    output logic [PC_W-1:0] trap_pc
);

    rob_state_e      state_q;
    rob_state_e      state_d;
    logic            take_fault;
    logic            cause_q;
    logic [PC_W-1:0] tpc_q;

    // State register together with the trap record captured on RUN-to-FLUSH.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_RUN;
            cause_q <= CAUSE_FAULT;
            tpc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take_fault || take_irq) begin
                cause_q <= take_irq ? CAUSE_IRQ : CAUSE_FAULT;
                tpc_q   <= hd_pc;
            end
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_RUN: begin
                if (take_fault || take_irq) begin
                    state_d = RS_FLUSH;
                end
            end
            RS_FLUSH: begin
                state_d = RS_RUN;
            end
            default: state_d = RS_RUN;
        endcase
    end

    // Outputs: fault outranks interrupt, interrupt outranks a commit.
    always_comb begin
        retire_go  = 1'b0;
        take_fault = 1'b0;
        take_irq   = 1'b0;
        flushing   = 1'b0;
        unique case (state_q)
            RS_RUN: begin
                take_fault = hd_valid && hd_done && hd_fault;
                take_irq   = hd_valid && irq_pend && !(hd_done && hd_fault);
                retire_go  = hd_valid && hd_done && !hd_fault && !irq_pend;
            end
            RS_FLUSH: begin
                flushing = 1'b1;
            end
            default: begin
                flushing = 1'b0;
            end
        endcase
    end

    assign trap_cause = cause_q;
    assign trap_pc    = tpc_q;

endmodule

// File: rtl/rob_core.sv
module rob_core #(
    parameter int DEPTH = 16,
    parameter int PC_W  = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [PC_W-1:0]  alloc_pc,
    input  logic             alloc_is_store,
    output logic             alloc_ready,
    output logic [IDX_W-1:0] alloc_tag,
    input  logic             cmpl_valid,
    input  logic [IDX_W-1:0] cmpl_tag,
    input  logic             cmpl_fault,
    input  logic             irq_req,
    output logic             retire_valid,
    output logic [PC_W-1:0]  retire_pc,
    output logic             store_release,
    output logic             trap_valid,
    output logic             trap_cause,
    output logic [PC_W-1:0]  trap_pc
);

    logic [IDX_W-1:0] head;
    logic [IDX_W-1:0] tail;
    logic             full;
    logic [CNT_W-1:0] occ;
    logic             push;
    logic             retire_go;
    logic             take_irq;
    logic             flushing;
    logic             irq_pend_q;
    logic             hd_valid;
    logic             hd_done;
    logic             hd_fault;
    logic             hd_store;
    logic [PC_W-1:0]  hd_pc;

    assign alloc_ready = !full && !flushing;
    assign push        = alloc_valid && alloc_ready;
    assign alloc_tag   = tail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pend_q <= 1'b0;
        end else begin
            irq_pend_q <= (irq_pend_q && !take_irq) || irq_req;
        end
    end

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (retire_go),
        .flush (flushing),
        .head  (head),
        .tail  (tail),
        .full  (full),
        .occ   (occ)
    );

    rob_entry_array #(.DEPTH(DEPTH), .PC_W(PC_W)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (push),
        .wr_idx    (tail),
        .wr_pc     (alloc_pc),
        .wr_store  (alloc_is_store),
        .cmp_en    (cmpl_valid),
        .cmp_idx   (cmpl_tag),
        .cmp_fault (cmpl_fault),
        .clr_en    (retire_go),
        .clr_idx   (head),
        .flush_all (flushing),
        .rd_idx    (head),
        .rd_valid  (hd_valid),
        .rd_done   (hd_done),
        .rd_fault  (hd_fault),
        .rd_store  (hd_store),
        .rd_pc     (hd_pc)
    );

    rob_retire_fsm #(.PC_W(PC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hd_valid   (hd_valid),
        .hd_done    (hd_done),
        .hd_fault   (hd_fault),
        .hd_pc      (hd_pc),
        .irq_pend   (irq_pend_q),
        .retire_go  (retire_go),
        .take_irq   (take_irq),
        .flushing   (flushing),
        .trap_cause (trap_cause),
        .trap_pc    (trap_pc)
    );

    assign retire_valid  = retire_go;
    assign retire_pc     = hd_pc;
    assign store_release = retire_go && hd_store;
    assign trap_valid    = flushing;

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic [IDX_W-1:0] alloc_tag,
    input logic             retire_valid,
    input logic             store_release,
    input logic             trap_valid,
    input logic [CNT_W-1:0] occ
);

    a_r1_tag_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |=>
            (alloc_tag == (($past(alloc_tag) == IDX_W'(DEPTH - 1)) ? '0 : $past(alloc_tag) + 1'b1)));

    a_r2_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH)) |-> !alloc_ready);

    a_r3_commit_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> (occ != '0));

    a_r6_release_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        store_release |-> retire_valid);

    a_r7_trap_had_entry: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> ($past(occ) != '0));

    a_r9_trap_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> !trap_valid);

    a_r9_no_alloc_in_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (!alloc_ready && !retire_valid));

    a_r9_empty_after_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (occ == '0));

endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_valid   (alloc_valid),
    .alloc_ready   (alloc_ready),
    .alloc_tag     (alloc_tag),
    .retire_valid  (retire_valid),
    .store_release (store_release),
    .trap_valid    (trap_valid),
    .occ           (occ)
);

// File: tb/rob_core_tb_top.sv
module rob_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int PC_W       = 32;
    localparam int IDX_W      = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_valid = 1'b0;
    logic [PC_W-1:0]  alloc_pc = '0;
    logic             alloc_is_store = 1'b0;
    logic             alloc_ready;
    logic [IDX_W-1:0] alloc_tag;
    logic             cmpl_valid = 1'b0;
    logic [IDX_W-1:0] cmpl_tag = '0;
    logic             cmpl_fault = 1'b0;
    logic             irq_req = 1'b0;
    logic             retire_valid;
    logic [PC_W-1:0]  retire_pc;
    logic             store_release;
    logic             trap_valid;
    logic             trap_cause;
    logic [PC_W-1:0]  trap_pc;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .PC_W(PC_W)) dut_i (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Reference state, built from the requirements only.
    logic [PC_W-1:0] m_pc [DEPTH];
    bit              m_st   [DEPTH];
    bit              m_done [DEPTH];
    bit              m_flt  [DEPTH];
    int              m_head = 0;
    int              m_cnt  = 0;
    bit              m_irq  = 1'b0;
    bit              m_flush = 1'b0;
    bit              m_cause = 1'b0;
    logic [PC_W-1:0] m_tpc = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pick_open();
        int off = int'($urandom_range(0, DEPTH - 1));
        for (int k = 0; k < DEPTH; k++) begin
            int j = (off + k) % DEPTH;
            if (j < m_cnt && !m_done[(m_head + j) % DEPTH]) begin
                return (m_head + j) % DEPTH;
            end
        end
        return -1;
    endfunction

    // One cycle: check outputs at the falling edge, drive inputs, advance the model.
    task automatic step(input bit av, input logic [PC_W-1:0] apc, input bit ast,
                        input bit cv, input int ctag, input bit cf, input bit irq);
        bit exp_ret;
        bit dec_flt;
        bit dec_irq;
        bit exp_rdy;
        bit hd_ok;
        int h;
        int tl;
        h       = m_head;
        tl      = (m_head + m_cnt) % DEPTH;
        exp_ret = 1'b0;
        dec_flt = 1'b0;
        dec_irq = 1'b0;
        if (!m_flush && m_cnt > 0) begin
            hd_ok = m_done[h];
            if (hd_ok && m_flt[h]) dec_flt = 1'b1;
            else if (m_irq) dec_irq = 1'b1;
            else if (hd_ok) exp_ret = 1'b1;
        end
        exp_rdy = !m_flush && (m_cnt < DEPTH);

        @(negedge clk);
        chk(alloc_ready == exp_rdy, "R2 R9 alloc_ready", 32'(alloc_ready), 32'(exp_rdy));
        chk(alloc_tag == IDX_W'(tl), "R1 alloc_tag", 32'(alloc_tag), 32'(tl));
        chk(retire_valid == exp_ret, "R3 R4 retire_valid", 32'(retire_valid), 32'(exp_ret));
        if (exp_ret) begin
            chk(retire_pc == m_pc[h], "R3 retire_pc", retire_pc, m_pc[h]);
        end
        chk(store_release == (exp_ret && m_st[h]), "R6 store_release",
            32'(store_release), 32'(exp_ret && m_st[h]));
        chk(trap_valid == m_flush, "R5 R7 R9 trap_valid", 32'(trap_valid), 32'(m_flush));
        if (m_flush) begin
            chk(trap_cause == m_cause, "R5 R8 trap_cause", 32'(trap_cause), 32'(m_cause));
            chk(trap_pc == m_tpc, "R5 R7 trap_pc", trap_pc, m_tpc);
        end

        alloc_valid    = av;
        alloc_pc       = apc;
        alloc_is_store = ast;
        cmpl_valid     = cv && (ctag >= 0);
        cmpl_tag       = IDX_W'(ctag);
        cmpl_fault     = cf;
        irq_req        = irq;
        @(posedge clk);

        if (m_flush) begin
            m_flush = 1'b0;
            m_cnt   = 0;
        end else begin
            if (cv && ctag >= 0) begin
                m_done[ctag] = 1'b1;
                m_flt[ctag]  = cf;
            end
            if (dec_flt || dec_irq) begin
                m_flush = 1'b1;
                m_cause = dec_irq;
                m_tpc   = m_pc[h];
                if (dec_irq) m_irq = 1'b0;
            end
            if (av && exp_rdy) begin
                m_pc[tl]   = apc;
                m_st[tl]   = ast;
                m_done[tl] = 1'b0;
                m_flt[tl]  = 1'b0;
                m_cnt++;
            end
            if (exp_ret) begin
                m_head = (m_head + 1) % DEPTH;
                m_cnt--;
            end
        end
        if (irq) m_irq = 1'b1;
    endtask

    task automatic drain();
        int t;
        while (m_cnt > 0 || m_flush) begin
            t = pick_open();
            step(1'b0, '0, 1'b0, t >= 0, t, 1'b0, 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int t;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin
            m_pc[i] = '0; m_st[i] = 1'b0; m_done[i] = 1'b0; m_flt[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: state straight after reset.
        @(negedge clk);
        chk(alloc_ready == 1'b1, "R10 alloc_ready", 32'(alloc_ready), 32'd1);
        chk(alloc_tag == '0, "R10 alloc_tag", 32'(alloc_tag), 32'd0);
        chk(!retire_valid && !store_release && !trap_valid, "R10 outputs idle",
            {29'd0, retire_valid, store_release, trap_valid}, 32'd0);

        // R2: fill past capacity without completions.
        for (int i = 0; i < DEPTH + 4; i++) begin
            step(1'b1, 32'h1000 + 32'(i * 4), i[0], 1'b0, 0, 1'b0, 1'b0);
        end
        // R4: complete in reverse order, nothing commits until slot 0 is done.
        for (int i = DEPTH - 1; i >= 0; i--) begin
            step(1'b0, '0, 1'b0, 1'b1, i, 1'b0, 1'b0);
        end
        drain();

        // R8: fault at head coincides with a new interrupt; interrupt then waits.
        step(1'b1, 32'h2000, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        step(1'b1, 32'h2004, 1'b1, 1'b0, 0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1, m_head, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        step(1'b1, 32'h3000, 1'b1, 1'b0, 0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, 1'b0, 0, 1'b0, 1'b0);

        // R5: younger fault held while older entry is incomplete.
        step(1'b1, 32'h4000, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        step(1'b1, 32'h4004, 1'b1, 1'b0, 0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1, (m_head + 1) % DEPTH, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1, m_head, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, 1'b0, 0, 1'b0, 1'b0);

        // Random traffic.
        for (int c = 0; c < 4000; c++) begin
            t = pick_open();
            step($urandom_range(0, 9) < 6, {$urandom_range(0, 32'hFFFF), 2'b00}, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 9) < 7, t, $urandom_range(0, 14) == 0, $urandom_range(0, 89) == 0);
        end
        drain();

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule